// File: doc/BRIEF.md
# Transmit Amplifier Enable and Bit Indicator

This block sits next to a frequency-shift modulator and handles two control lines. The first is an active-low enable for an external power amplifier. It is driven low once the chip enters transmit mode. When transmission ends it is held low for a programmable number of clock cycles, so the amplifier does not cut off the last part of the waveform. The second line is an indicator that reports which tone is on the line. A 0 means the space tone is being sent, and a 1 means the mark tone is being sent.

The indicator is updated only when the bit clock strobe is present. This makes it change exactly at bit boundaries. Outside transmission, the next strobe sets it to 1. A return to transmit mode while the hold window is running cancels the window. The amplifier then stays enabled with no glitch.

Both outputs come directly from registers. All inputs are sampled on the rising clock edge, and the reset is synchronous and active-high.

Top module: `txc_ctrl`

## Requirements
- R1: At the first clock edge that samples `tx_mode`=1, `pa_en_n` goes to 0. It stays at 0 for as long as `tx_mode` remains 1.
- R2: Let edge k be the first edge that samples `tx_mode`=0 after transmission. `pa_en_n` stays 0 through edge k+HOLD_CYCLES-1 and becomes 1 at edge k+HOLD_CYCLES. When HOLD_CYCLES=0, it becomes 1 at edge k.
- R3: If `tx_mode` returns to 1 while the hold window is running, the window is cancelled and `pa_en_n` stays 0. A later exit from transmit starts a full new window of HOLD_CYCLES.
- R4: At an edge with `bit_strobe`=1 and `tx_mode`=1, `tx_ind` takes the value of `tx_bit`. Here 0 means the space tone and 1 means the mark tone.
- R5: `tx_ind` keeps its value at every edge where `bit_strobe`=0.
- R6: At an edge with `bit_strobe`=1 and `tx_mode`=0, `tx_ind` becomes 1. This includes edges inside the hold window. It does not change before that strobe.
- R7: After reset, `pa_en_n`=1 and `tx_ind`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| bit_strobe | input | 1 | One-cycle bit clock strobe |
| tx_bit | input | 1 | Current data bit (0 space, 1 mark) |
| pa_en_n | output | 1 | Amplifier enable, active low |
| tx_ind | output | 1 | Transmitted-tone indicator |

## Verification
The bound checker follows a count of receive cycles since the last transmit cycle. On every cycle it checks that the amplifier enable matches that count against the hold length. It also checks, on every cycle, how the indicator responds to strobes, and that the indicator stays steady between strobes.

The bench scenarios are what show the rest. They show the reset values, and they show that a cancelled hold followed by a second exit measures a full new window. They also show, counting edge by edge, how long the enable stays low after transmission ends.

// File: rtl/txc_pkg.sv
package txc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HOLD   = 2'd2
  } pa_state_t;
endpackage

// File: rtl/txc_hold_timer.sv
module txc_hold_timer
  import txc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned HOLD_CYCLES = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_mode,
  output logic pa_en_n
);
  localparam bit              ZERO_HOLD = (HOLD_CYCLES == 0);
  localparam logic [CNT_W-1:0] LOAD_VAL = ZERO_HOLD ? '0 : CNT_W'(HOLD_CYCLES - 1);

  pa_state_t        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pa_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      pa_q  <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (tx_mode) begin
            st_q <= ST_ACTIVE;
            pa_q <= 1'b0;
          end
        end
        ST_ACTIVE: begin
          if (!tx_mode) begin
            if (ZERO_HOLD) begin
              st_q <= ST_IDLE;
              pa_q <= 1'b1;
            end else begin
              st_q  <= ST_HOLD;
              cnt_q <= LOAD_VAL;
            end
          end
        end
        ST_HOLD: begin
          if (tx_mode) begin
            st_q <= ST_ACTIVE;
          end else if (cnt_q == '0) begin
            st_q <= ST_IDLE;
            pa_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          st_q <= ST_IDLE;
          pa_q <= 1'b1;
        end
      endcase
    end
  end

  assign pa_en_n = pa_q;
endmodule

// File: rtl/txc_bit_tracker.sv
module txc_bit_tracker (
  input  logic clk,
  input  logic rst,
  input  logic tx_mode,
  input  logic bit_strobe,
  input  logic tx_bit,
  output logic tx_ind
);
  logic ind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_q <= 1'b1;
    end else if (bit_strobe) begin
      ind_q <= tx_mode ? tx_bit : 1'b1;
    end
  end

  assign tx_ind = ind_q;
endmodule

// File: rtl/txc_ctrl.sv
module txc_ctrl #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned HOLD_CYCLES = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_mode,
  input  logic bit_strobe,
  input  logic tx_bit,
  output logic pa_en_n,
  output logic tx_ind
);
  txc_hold_timer #(
    .CNT_W      (CNT_W),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tx_mode(tx_mode),
    .pa_en_n(pa_en_n)
  );

  txc_bit_tracker u_bits (
    .clk       (clk),
    .rst       (rst),
    .tx_mode   (tx_mode),
    .bit_strobe(bit_strobe),
    .tx_bit    (tx_bit),
    .tx_ind    (tx_ind)
  );
endmodule

// File: rtl/txc_ctrl_chk.sv
module txc_ctrl_chk #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned HOLD_CYCLES = 1200
) (
  input logic clk,
  input logic rst,
  input logic tx_mode,
  input logic bit_strobe,
  input logic tx_bit,
  input logic pa_en_n,
  input logic tx_ind
);
  localparam logic [CNT_W:0] HOLD_X = (CNT_W+1)'(HOLD_CYCLES);

  logic [CNT_W:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) idle_cnt <= HOLD_X + 1'b1;
    else if (tx_mode) idle_cnt <= '0;
    else if (idle_cnt <= HOLD_X) idle_cnt <= idle_cnt + 1'b1;
  end

  AST_TX_ENABLE_LOW: assert property (@(posedge clk) disable iff (rst) tx_mode |=> !pa_en_n); // R1
  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (rst) pa_en_n == (idle_cnt > HOLD_X)); // R2
  AST_HOLD_CANCEL: assert property (@(posedge clk) disable iff (rst) (idle_cnt != 0 && idle_cnt <= HOLD_X && tx_mode) |=> !pa_en_n); // R3
  AST_BIT_FOLLOW: assert property (@(posedge clk) disable iff (rst) (bit_strobe && tx_mode) |=> tx_ind == $past(tx_bit)); // R4
  AST_BIT_STABLE: assert property (@(posedge clk) disable iff (rst) !bit_strobe |=> $stable(tx_ind)); // R5
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst) (bit_strobe && !tx_mode) |=> tx_ind); // R6
endmodule

bind txc_ctrl txc_ctrl_chk #(
  .CNT_W      (CNT_W),
  .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_mode   (tx_mode),
  .bit_strobe(bit_strobe),
  .tx_bit    (tx_bit),
  .pa_en_n   (pa_en_n),
  .tx_ind    (tx_ind)
);

// File: tb/tb_txc_ctrl.sv
module tb_txc_ctrl;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_mode = 1'b0;
  logic bit_strobe = 1'b0;
  logic tx_bit = 1'b0;
  logic pa_en_n, tx_ind;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R7";

  // reference model state
  int m_idle = HOLD + 1;
  bit m_pa = 1'b1;
  bit m_ind = 1'b1;

  always #4 clk = ~clk;

  txc_ctrl #(.CNT_W(16), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst(rst), .tx_mode(tx_mode), .bit_strobe(bit_strobe),
    .tx_bit(tx_bit), .pa_en_n(pa_en_n), .tx_ind(tx_ind)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_idle = HOLD + 1; m_pa = 1'b1; m_ind = 1'b1;
    end else begin
      if (tx_mode) m_idle = 0;
      else if (m_idle <= HOLD) m_idle++;
      m_pa = (m_idle > HOLD);
      if (bit_strobe) m_ind = tx_mode ? tx_bit : 1'b1;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // compare against model, then apply next inputs
  task automatic step(input logic m, input logic s, input logic b);
    @(negedge clk);
    if (!rst) begin
      check(cur_req, "pa_en_n", pa_en_n, m_pa);
      check(cur_req, "tx_ind", tx_ind, m_ind);
    end
    tx_mode = m; bit_strobe = s; tx_bit = b;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7", "reset pa_en_n", pa_en_n, 1'b1);
    check("R7", "reset tx_ind", tx_ind, 1'b1);

    // R6: idle with no strobe keeps 1; strobe in idle keeps 1
    cur_req = "R6";
    repeat (3) step(0, 0, 0);
    step(0, 1, 0);
    step(0, 0, 0);

    // R1: enter transmit, enable falls after first sampling edge
    cur_req = "R1";
    step(1, 0, 0);
    @(negedge clk);
    check("R1", "enable low after entry", pa_en_n, 1'b0);
    check("R5", "indicator unchanged without strobe", tx_ind, 1'b1);

    // R4/R5: bit pattern, strobe every 4 cycles
    cur_req = "R4";
    for (int i = 0; i < 8; i++) begin
      logic bv;
      bv = logic'((8'b1011_0010 >> i) & 1);
      step(1, 1, bv);
      cur_req = "R5";
      step(1, 0, ~bv);
      step(1, 0, ~bv);
      step(1, 0, bv);
      cur_req = "R4";
    end
    step(1, 1, 1'b0);
    @(negedge clk);
    check("R4", "space bit reported", tx_ind, 1'b0);

    // R2: measure hold length
    cur_req = "R2";
    tx_mode = 1'b0; bit_strobe = 1'b0;
    n = 0;
    for (int i = 0; i < HOLD + 5; i++) begin
      @(negedge clk);
      if (pa_en_n === 1'b0) n++;
      else break;
    end
    total++;
    if (n != HOLD) begin
      bad++;
      $display("FAIL R2 hold length: actual=%0d expected=%0d", n, HOLD);
    end
    check("R6", "indicator waits for strobe", tx_ind, 1'b0);
    step(0, 1, 0);
    @(negedge clk);
    check("R6", "indicator 1 after idle strobe", tx_ind, 1'b1);

    // R3: cancel during hold, then full new window
    cur_req = "R3";
    step(1, 0, 0);
    repeat (3) step(1, 0, 0);
    repeat (HOLD / 2) step(0, 0, 0);
    step(1, 1, 0);
    step(1, 0, 0);
    @(negedge clk);
    check("R3", "enable held after cancel", pa_en_n, 1'b0);
    check("R4", "space after cancel", tx_ind, 1'b0);
    tx_mode = 1'b0; bit_strobe = 1'b0;
    n = 0;
    for (int i = 0; i < HOLD + 5; i++) begin
      @(negedge clk);
      if (pa_en_n === 1'b0) n++;
      else break;
    end
    total++;
    if (n != HOLD) begin
      bad++;
      $display("FAIL R3 new window length: actual=%0d expected=%0d", n, HOLD);
    end

    // R6: strobe inside hold window sets indicator
    cur_req = "R6";
    step(1, 1, 0);
    step(0, 0, 0);
    step(0, 1, 0);
    step(0, 0, 0);
    @(negedge clk);
    check("R6", "idle strobe in hold", tx_ind, 1'b1);
    check("R2", "still in hold", pa_en_n, 1'b0);
    repeat (HOLD + 2) step(0, 0, 0);

    // R7: reset mid-transmission
    step(1, 1, 0);
    step(1, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    tx_mode = 1'b0;
    @(negedge clk);
    check("R7", "reset pa_en_n mid-tx", pa_en_n, 1'b1);
    check("R7", "reset tx_ind mid-tx", tx_ind, 1'b1);
    finish_run();
  end
endmodule